// File: doc/BRIEF.md
# Asynchronous Timer Register Bridge

This block sits between the system bus and an 8-bit timer whose counting clock is either the system clock or a slow external oscillator. It owns three timer registers (the running count, the match value and the mode byte) plus a status byte. In oscillator mode every bus write to a timer register is parked in a per-register holding stage. It is then carried into the slow domain with a toggle request, committed there, and acknowledged back. While this round trip is under way, a busy flag for that register is visible on the bus.

In system-clock mode the timer shares the bus clock, and a write goes straight to its destination on the next edge with no busy phase. Software selects the source through the status byte. It should switch only while the timer is stopped and no transfer is pending.

Top module: `atmr_bridge`

## Requirements
- R1: A bus write to the match register (address 1) or mode register (address 2) lands in that register's holding stage. A read of address 1 or 2 returns the holding stage from the cycle after the write.
- R2: In oscillator mode the destination of a write is loaded at the second rising oscillator edge after the write. Its busy flag then drops on the second system clock edge after that load.
- R3: In oscillator mode a write to an idle register raises its busy flag in the cycle after the write.
- R4: The three registers transfer independently. A write to one neither delays nor alters a transfer in flight for another.
- R5: The status byte at address 3 reads bits 7..4 as zero. Bit 3 is the source select (1 = oscillator, 0 = system clock) and is writable. Bits 2, 1 and 0 are the busy flags of count, match and mode, and writes to them have no effect. Every bit resets to 0.
- R6: With source select 0, busy flags never rise and a write reaches its destination on the next system clock edge.
- R7: A read of address 0 returns the count. In system-clock mode this is the live value. In oscillator mode it is a snapshot that equals the live count once the count has stopped.
- R8: While mode bit 0 is set, the count rises by one, wrapping from 0xFF to 0x00, on every edge of the selected timer clock. A committed count write wins over the increment on its edge.
- R9: A write to a register whose busy flag is set updates the holding stage, and the busy flag stays set until the pending transfer completes.
- R10: While a register is busy and not rewritten, its holding stage does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System/bus clock |
| clk_osc | input | 1 | Slow oscillator clock, below a quarter of clk_sys |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_addr | input | 2 | 0 count, 1 match, 2 mode, 3 status |
| bus_wr | input | 1 | Write strobe, one system cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| tmr_count | output | DATA_W | Live counter value (timer domain) |
| tmr_match | output | DATA_W | Committed match value (timer domain) |
| tmr_mode | output | DATA_W | Committed mode byte (timer domain) |

## Verification
The bench first drives single isolated writes in both clock modes, which separates direct loading from the two-edge commit and the two-cycle busy release. It then issues overlapping writes to different registers to expose any coupling between channels. Back-to-back writes to one register probe that the busy flag survives a protocol violation. A counter that runs across a committed count write, and across its wrap, distinguishes write priority from increment. Finally, reading the count after a stop tells the snapshot path apart from a stale capture.

// File: rtl/atmr_pkg.sv
package atmr_pkg;
   typedef enum logic [1:0] {
      RG_COUNT  = 2'd0,
      RG_MATCH  = 2'd1,
      RG_MODE   = 2'd2,
      RG_STATUS = 2'd3
   } reg_sel_e;

   localparam int NUM_CH     = 3;
   localparam int ST_SRC_BIT = 3;
endpackage

// File: rtl/atmr_sync.sv
module atmr_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 1) begin : g_bad
         $error("atmr_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [W-1:0] st [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[0] <= '0;
            else        st[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[i] <= '0;
            else        st[i] <= st[i-1];
         end
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/atmr_xfer.sv
module atmr_xfer #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk_sys,
   input  logic         clk_tmr,
   input  logic         rst_n,
   input  logic         async_mode,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] hold,
   output logic         busy,
   output logic         load,
   output logic [W-1:0] load_val
);
   logic req_q;
   logic arrive;
   logic done_q;
   logic done_sys;
   logic commit;

   // system side: holding stage and request toggle
   always_ff @(posedge clk_sys or negedge rst_n) begin
      if (!rst_n) begin
         hold  <= '0;
         req_q <= 1'b0;
      end else if (wr) begin
         hold <= wdata;
         if (async_mode && !busy) req_q <= ~req_q;
      end
   end

   // completion toggle back into the system domain
   atmr_sync #(.STAGES(STAGES), .W(1)) u_ack (
      .clk(clk_sys), .rst_n(rst_n), .d(done_q), .q(done_sys)
   );
   assign busy = req_q ^ done_sys;

   // timer side: first STAGES-1 flops, last flop doubles as the commit edge
   atmr_sync #(.STAGES(STAGES-1), .W(1)) u_req (
      .clk(clk_tmr), .rst_n(rst_n), .d(req_q), .q(arrive)
   );

   always_ff @(posedge clk_tmr or negedge rst_n) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= arrive;
   end

   assign commit   = arrive ^ done_q;
   assign load     = async_mode ? commit : wr;
   assign load_val = async_mode ? hold : wdata;
endmodule

// File: rtl/atmr_snap.sv
module atmr_snap #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk_sys,
   input  logic         clk_tmr,
   input  logic         rst_n,
   input  logic [W-1:0] live,
   output logic [W-1:0] snap
);
   logic tick_q;
   logic tick_s;
   logic tick_d;

   always_ff @(posedge clk_tmr or negedge rst_n) begin
      if (!rst_n) tick_q <= 1'b0;
      else        tick_q <= ~tick_q;
   end

   atmr_sync #(.STAGES(STAGES), .W(1)) u_tick (
      .clk(clk_sys), .rst_n(rst_n), .d(tick_q), .q(tick_s)
   );

   // capture only after the timer edge has settled for STAGES system cycles
   always_ff @(posedge clk_sys or negedge rst_n) begin
      if (!rst_n) begin
         tick_d <= 1'b0;
         snap   <= '0;
      end else begin
         tick_d <= tick_s;
         if (tick_s ^ tick_d) snap <= live;
      end
   end
endmodule

// File: rtl/atmr_bridge.sv
module atmr_bridge
   import atmr_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int RUN_BIT     = 0
) (
   input  logic              clk_sys,
   input  logic              clk_osc,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [DATA_W-1:0] tmr_count,
   output logic [DATA_W-1:0] tmr_match,
   output logic [DATA_W-1:0] tmr_mode
);
   generate
      if (DATA_W < 4) begin : g_bad_w
         $error("atmr_bridge: DATA_W must hold the status layout");
      end
      if (SYNC_STAGES < 2) begin : g_bad_s
         $error("atmr_bridge: SYNC_STAGES must be at least 2");
      end
      if (RUN_BIT >= DATA_W) begin : g_bad_r
         $error("atmr_bridge: RUN_BIT outside mode byte");
      end
   endgenerate

   localparam int CH_CNT = 0;
   localparam int CH_MAT = 1;
   localparam int CH_MOD = 2;

   logic              src_q;
   logic              tmr_clk;
   logic [NUM_CH-1:0] wr_ch;
   logic [NUM_CH-1:0] busy_v;
   logic [NUM_CH-1:0] load_v;
   logic [DATA_W-1:0] hold_q   [NUM_CH];
   logic [DATA_W-1:0] load_val [NUM_CH];
   logic [DATA_W-1:0] dest_q   [NUM_CH];
   logic [DATA_W-1:0] cnt_snap;
   logic [DATA_W-1:0] status;

   // source select
   always_ff @(posedge clk_sys or negedge rst_n) begin
      if (!rst_n) src_q <= 1'b0;
      else if (bus_wr && bus_addr == RG_STATUS) src_q <= bus_wdata[ST_SRC_BIT];
   end

   assign tmr_clk = src_q ? clk_osc : clk_sys;

   // one transfer channel per timer register
   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      assign wr_ch[ch] = bus_wr && (bus_addr == 2'(ch));

      atmr_xfer #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_xfer (
         .clk_sys    (clk_sys),
         .clk_tmr    (tmr_clk),
         .rst_n      (rst_n),
         .async_mode (src_q),
         .wr         (wr_ch[ch]),
         .wdata      (bus_wdata),
         .hold       (hold_q[ch]),
         .busy       (busy_v[ch]),
         .load       (load_v[ch]),
         .load_val   (load_val[ch])
      );

      if (ch == CH_CNT) begin : g_counter
         always_ff @(posedge tmr_clk or negedge rst_n) begin
            if (!rst_n)                        dest_q[ch] <= '0;
            else if (load_v[ch])               dest_q[ch] <= load_val[ch];
            else if (dest_q[CH_MOD][RUN_BIT])  dest_q[ch] <= dest_q[ch] + 1'b1;
         end
      end else begin : g_plain
         always_ff @(posedge tmr_clk or negedge rst_n) begin
            if (!rst_n)          dest_q[ch] <= '0;
            else if (load_v[ch]) dest_q[ch] <= load_val[ch];
         end
      end
   end

   assign tmr_count = dest_q[CH_CNT];
   assign tmr_match = dest_q[CH_MAT];
   assign tmr_mode  = dest_q[CH_MOD];

   atmr_snap #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_snap (
      .clk_sys (clk_sys),
      .clk_tmr (tmr_clk),
      .rst_n   (rst_n),
      .live    (dest_q[CH_CNT]),
      .snap    (cnt_snap)
   );

   always_comb begin
      status             = '0;
      status[ST_SRC_BIT] = src_q;
      status[2]          = busy_v[CH_CNT];
      status[1]          = busy_v[CH_MAT];
      status[0]          = busy_v[CH_MOD];
   end

   always_comb begin
      unique case (bus_addr)
         RG_COUNT: bus_rdata = src_q ? cnt_snap : dest_q[CH_CNT];
         RG_MATCH: bus_rdata = hold_q[CH_MAT];
         RG_MODE:  bus_rdata = hold_q[CH_MOD];
         default:  bus_rdata = status;
      endcase
   end
endmodule

// File: rtl/atmr_bridge_chk.sv
module atmr_bridge_chk #(
   parameter int DATA_W  = 8,
   parameter int RUN_BIT = 0
) (
   input logic              clk_sys,
   input logic              rst_n,
   input logic [1:0]        bus_addr,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              src_q,
   input logic [2:0]        busy_v,
   input logic [DATA_W-1:0] hold_match,
   input logic [DATA_W-1:0] tmr_count,
   input logic [DATA_W-1:0] tmr_match,
   input logic [DATA_W-1:0] tmr_mode
);
   p_busy_set_r3: assert property (@(posedge clk_sys) disable iff (!rst_n)
      (src_q && bus_wr && bus_addr == 2'd1 && !busy_v[1]) |=> busy_v[1]);

   p_hold_stable_r10: assert property (@(posedge clk_sys) disable iff (!rst_n)
      (busy_v[1] && !(bus_wr && bus_addr == 2'd1)) |=> $stable(hold_match));

   p_no_busy_sync_r6: assert property (@(posedge clk_sys) disable iff (!rst_n)
      (!src_q && busy_v == 3'b000) |=> busy_v == 3'b000);

   p_direct_load_r6: assert property (@(posedge clk_sys) disable iff (!rst_n)
      (!src_q && bus_wr && bus_addr == 2'd2) |=> tmr_mode == $past(bus_wdata));

   p_idle_dest_r2: assert property (@(posedge clk_sys) disable iff (!rst_n)
      (src_q && !busy_v[1] && !(bus_wr && bus_addr == 2'd1)) |=> $stable(tmr_match));

   p_count_step_r8: assert property (@(posedge clk_sys) disable iff (!rst_n)
      (!src_q && tmr_mode[RUN_BIT] && !bus_wr) |=> tmr_count == DATA_W'($past(tmr_count) + 1'b1));
endmodule

bind atmr_bridge atmr_bridge_chk #(.DATA_W(DATA_W), .RUN_BIT(RUN_BIT)) u_chk (
   .clk_sys    (clk_sys),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_wr     (bus_wr),
   .bus_wdata  (bus_wdata),
   .src_q      (src_q),
   .busy_v     (busy_v),
   .hold_match (hold_q[1]),
   .tmr_count  (tmr_count),
   .tmr_match  (tmr_match),
   .tmr_mode   (tmr_mode)
);

// File: tb/tb_atmr_bridge.sv
module tb_atmr_bridge;
   localparam int STG = 2;

   logic       clk_sys = 1'b0;
   logic       clk_osc = 1'b0;
   logic       rst_n   = 1'b0;
   logic [1:0] bus_addr  = 2'd3;
   logic       bus_wr    = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata, tmr_count, tmr_match, tmr_mode;

   atmr_bridge dut (
      .clk_sys(clk_sys), .clk_osc(clk_osc), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .tmr_count(tmr_count),
      .tmr_match(tmr_match), .tmr_mode(tmr_mode)
   );

   always #2 clk_sys = ~clk_sys;            // 250 MHz
   initial begin
      #1;
      forever #20 clk_osc = ~clk_osc;       // 10 system cycles, never coincident
   end

   // behavioural reference model
   bit         sel_m;
   logic [7:0] hold_m [3];
   logic [7:0] dest_m [3];
   bit         busy_m [3];
   bit         known  [3];
   bit         spoilt [3];
   int         ph [3], se [3], cc [3];
   int         viol;
   bit         chk_cnt;
   string      tag = "R5";
   int         n_chk, n_bad;
   bit         done;

   initial begin
      for (int k = 0; k < 3; k++) begin
         hold_m[k] = '0; dest_m[k] = '0; busy_m[k] = 0;
         known[k] = 1; spoilt[k] = 0; ph[k] = 0; se[k] = 0; cc[k] = 0;
      end
      sel_m = 0; viol = 0; chk_cnt = 0;
   end

   always @(posedge clk_sys) begin
      if (rst_n) begin
         bit   sel_old, run_old;
         int   k;
         sel_old = sel_m;
         run_old = dest_m[2][0];
         if (bus_wr) begin
            if (bus_addr == 2'd3) sel_m = bus_wdata[3];
            else begin
               k = int'(bus_addr);
               hold_m[k] = bus_wdata;
               if (sel_old) begin
                  if (!busy_m[k]) begin
                     busy_m[k] = 1; ph[k] = 1; se[k] = 0; spoilt[k] = 0;
                  end else begin
                     viol++; spoilt[k] = 1; known[k] = 0;
                     $display("note: protocol violation, write to busy register %0d", k);
                  end
               end else dest_m[k] = bus_wdata;
            end
         end
         if (!sel_old && !(bus_wr && bus_addr == 2'd0) && run_old) dest_m[0] = dest_m[0] + 8'd1;
         for (int j = 0; j < 3; j++)
            if (ph[j] == 2) begin
               cc[j]++;
               if (cc[j] == STG) begin busy_m[j] = 0; ph[j] = 0; end
            end
      end
   end

   always @(posedge clk_osc) begin
      if (rst_n && sel_m) begin
         bit run_old, cnt_loaded;
         run_old = dest_m[2][0];
         cnt_loaded = 0;
         for (int j = 0; j < 3; j++)
            if (ph[j] == 1) begin
               se[j]++;
               if (se[j] == 2) begin
                  dest_m[j] = hold_m[j]; ph[j] = 2; cc[j] = 0;
                  known[j] = !spoilt[j];
                  if (j == 0) cnt_loaded = 1;
               end
            end
         if (!cnt_loaded && run_old) dest_m[0] = dest_m[0] + 8'd1;
      end
   end

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s (%s): actual %02h expected %02h at %0t", req, tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      case (bus_addr)
         2'd0: if (!sel_m || chk_cnt) chk("R7", bus_rdata, dest_m[0]);
         2'd1: chk("R1", bus_rdata, hold_m[1]);
         2'd2: chk("R1", bus_rdata, hold_m[2]);
         default: chk("R5", bus_rdata, {4'b0, sel_m, busy_m[0], busy_m[1], busy_m[2]});
      endcase
      if (known[1]) chk("R2", tmr_match, dest_m[1]);
      if (known[2]) chk("R4", tmr_mode, dest_m[2]);
      if (known[0]) chk("R8", tmr_count, dest_m[0]);
   endtask

   task automatic cyc(logic [1:0] a, logic w, logic [7:0] d);
      @(negedge clk_sys);
      compare_all();
      bus_addr = a; bus_wr = w; bus_wdata = d;
   endtask

   task automatic idle(logic [1:0] a, int n);
      for (int i = 0; i < n; i++) cyc(a, 1'b0, 8'h00);
   endtask

   initial begin
      repeat (5) @(negedge clk_sys);
      rst_n = 1'b1;
      // reset state R5
      tag = "R5"; idle(2'd3, 2); idle(2'd1, 1); idle(2'd0, 1);

      // system-clock mode: direct loads R6, counting R8
      tag = "R6";
      cyc(2'd1, 1, 8'h5A); cyc(2'd1, 0, 0); cyc(2'd0, 1, 8'h10); cyc(2'd3, 0, 0);
      tag = "R8";
      cyc(2'd2, 1, 8'h01); idle(2'd0, 6);
      cyc(2'd0, 1, 8'hFD); idle(2'd0, 6);       // priority then wrap
      cyc(2'd2, 1, 8'h00); idle(2'd0, 3);

      // switch to oscillator, read-only busy bits R5
      tag = "R5";
      cyc(2'd3, 1, 8'hFF); idle(2'd3, 4);

      // single write, busy rise and release R3 R2 R10
      tag = "R3";
      cyc(2'd1, 1, 8'hA5); tag = "R10"; idle(2'd1, 3); tag = "R2"; idle(2'd3, 40);

      // overlapping channels R4
      tag = "R4";
      cyc(2'd1, 1, 8'h3C); cyc(2'd2, 1, 8'h01); idle(2'd3, 40);

      // counter runs in slow domain, committed write wins R8
      tag = "R8";
      idle(2'd3, 25);
      cyc(2'd0, 1, 8'h20); idle(2'd3, 60);

      // protocol violation R9
      tag = "R9";
      cyc(2'd1, 1, 8'h11); cyc(2'd1, 1, 8'h22); idle(2'd3, 3); idle(2'd1, 2); idle(2'd3, 40);
      cyc(2'd1, 1, 8'h33); idle(2'd3, 40);

      // stop and read snapshot R7
      tag = "R7";
      cyc(2'd2, 1, 8'h00); idle(2'd3, 40);
      chk_cnt = 1; idle(2'd0, 5); chk_cnt = 0;

      // back to system clock R6
      tag = "R6";
      cyc(2'd3, 1, 8'h00); idle(2'd3, 3);
      cyc(2'd1, 1, 8'h77); idle(2'd3, 3); cyc(2'd2, 1, 8'h04); idle(2'd1, 3);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule